// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching one page table entry from memory. A requester presents the virtual address together with the kind of access (data read, data write or instruction fetch). The walker takes the page number from the upper address bits and uses it directly as an index into a flat table whose start address is held in a table-base register. It reads the entry through a simple request/acknowledge memory port, checks it and answers with either the physical address or a fault code.

Because the entry is checked in hardware, the walker also keeps the page status bits current. Any successful access marks the page as referenced, and a successful write also marks it as modified. The updated entry is written back to the same location only when one of those bits actually changes. A missing page and a forbidden access raise two different fault codes. Neither fault returns a translation, and neither writes to memory. The table-base register is loaded from a side input, as a context switch would do.

Top module: `pgw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both high, and no other request is taken until its response has been given.
- R2: The entry is read from word address base + (virtual page number × 4). The page number is bits 31:12 of the virtual address, and the base is the table-base value at the time the request is taken.
- R3: On success, `rsp_fault` is 00 and `rsp_paddr` is entry bits 31:12 followed by virtual address bits 11:0. For example, address 0x13325328 with entry frame 0x03004 gives 0x03004328.
- R4: If entry bit 0 (present) is clear, the response carries fault 01 and a physical address of 0, and nothing is written to memory. This fault takes priority over a permission fault.
- R5: Access codes are 00 read, 01 write, 10 fetch, and 11, which is treated as a read. Entry bit 3 allows reads, bit 4 allows writes and bit 5 allows fetches. A present entry whose matching bit is clear gives fault 10, a physical address of 0, and no memory write.
- R6: On success, the entry is written back to the address it was read from with bit 1 (referenced) set, with bit 2 (modified) also set for a write, and with all other bits unchanged.
- R7: No write-back occurs when the referenced bit and, for a write, the modified bit are already set.
- R8: `rsp_valid` is a one-cycle pulse, given exactly once for each request taken.
- R9: A pulse on `base_load` stores `base_value` in the table-base register. It affects only requests taken after the load, never a walk already in progress.
- R10: After reset, `req_ready` is 1, `rsp_valid` and `mem_req` are 0, and the table-base register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_load | input | 1 | Loads the table-base register |
| base_value | input | 32 | New table-base address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Physical address, or 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 page not present, 10 permission denied |
| mem_req | output | 1 | Memory access pending, held until acknowledged |
| mem_we | output | 1 | Pending access is a write |
| mem_addr | output | 32 | Byte address of the page table entry |
| mem_wdata | output | 32 | Updated entry for a write-back |
| mem_ack | input | 1 | Memory finished the pending access this cycle |
| mem_rdata | input | 32 | Entry read, valid together with `mem_ack` |

## Verification
The assertions assume that the memory raises `mem_ack` only while `mem_req` is high, for a single cycle per access, and returns the read entry in that same cycle. The bench memory model acknowledges one cycle after it sees a request and then drops the acknowledge, so it never acknowledges twice. Requests are driven between clock edges, and a base load that happens during a walk is timed after that walk has been taken, so the R9 check sees the old base without any race at the clock edge.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_ALT   = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'b00,
      FLT_ABSENT  = 2'b01,
      FLT_DENIED  = 2'b10
   } flt_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_EVAL,
      ST_STORE,
      ST_REPLY
   } st_e;

   localparam int unsigned BIT_PRESENT = 0;
   localparam int unsigned BIT_REF     = 1;
   localparam int unsigned BIT_DIRTY   = 2;
   localparam int unsigned BIT_CAN_RD  = 3;
   localparam int unsigned BIT_CAN_WR  = 4;
   localparam int unsigned BIT_CAN_EX  = 5;
   localparam int unsigned FLAG_BITS   = 6;
endpackage

// File: rtl/pgw_entry_addr.sv
module pgw_entry_addr #(
   parameter int unsigned VPN_W       = 20,
   parameter int unsigned PA_W        = 32,
   parameter int unsigned ENTRY_SHIFT = 2,
   parameter bit          BASE_ALIGNED = 1'b0
) (
   input  logic [PA_W-1:0]  base,
   input  logic [VPN_W-1:0] vpn,
   output logic [PA_W-1:0]  entry_addr
);
   localparam int unsigned SCALED_W = VPN_W + ENTRY_SHIFT;

   if (SCALED_W > PA_W) begin : g_bad_width
      $error("pgw_entry_addr: scaled page number wider than physical address");
   end

   logic [PA_W-1:0] scaled;
   assign scaled = PA_W'(vpn) << ENTRY_SHIFT;

   if (BASE_ALIGNED) begin : g_merge
      // Table is aligned to its own size, so the index simply fills low bits.
      assign entry_addr = base | scaled;
   end else begin : g_add
      assign entry_addr = base + scaled;
   end
endmodule

// File: rtl/pgw_entry_check.sv
module pgw_entry_check
   import pgw_pkg::*;
#(
   parameter int unsigned PTE_W = 32
) (
   input  logic [PTE_W-1:0] entry,
   input  logic [1:0]       acc,
   output logic [1:0]       fault,
   output logic [PTE_W-1:0] entry_upd,
   output logic             needs_store
);
   if (PTE_W < FLAG_BITS) begin : g_bad_pte
      $error("pgw_entry_check: entry too narrow for status flags");
   end

   logic allowed;
   logic is_write;

   always_comb begin
      is_write = (acc == ACC_WRITE);
      unique case (acc)
         ACC_WRITE: allowed = entry[BIT_CAN_WR];
         ACC_FETCH: allowed = entry[BIT_CAN_EX];
         default:   allowed = entry[BIT_CAN_RD];
      endcase
   end

   always_comb begin
      if (!entry[BIT_PRESENT])
         fault = FLT_ABSENT;
      else if (!allowed)
         fault = FLT_DENIED;
      else
         fault = FLT_NONE;
   end

   always_comb begin
      entry_upd = entry;
      entry_upd[BIT_REF] = 1'b1;
      if (is_write)
         entry_upd[BIT_DIRTY] = 1'b1;
   end

   assign needs_store = (fault == FLT_NONE) && (entry_upd != entry);
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
   import pgw_pkg::*;
#(
   parameter int unsigned PA_W      = 32,
   parameter int unsigned PTE_W     = 32,
   parameter int unsigned PAGE_BITS = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take,
   input  logic [PA_W-1:0]      entry_addr,
   input  logic [PAGE_BITS-1:0] offset,
   input  logic [1:0]           acc,
   output logic                 idle,
   output logic [PTE_W-1:0]     entry_q,
   output logic [1:0]           acc_q,
   input  logic [1:0]           chk_fault,
   input  logic [PTE_W-1:0]     chk_upd,
   input  logic                 chk_store,
   output logic                 rsp_valid,
   output logic [PA_W-1:0]      rsp_paddr,
   output logic [1:0]           rsp_fault,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [PA_W-1:0]      mem_addr,
   output logic [PTE_W-1:0]     mem_wdata,
   input  logic                 mem_ack,
   input  logic [PTE_W-1:0]     mem_rdata
);
   localparam int unsigned FRAME_W = PA_W - PAGE_BITS;

   st_e                  state;
   logic [PAGE_BITS-1:0] off_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mem_addr  <= '0;
         mem_wdata <= '0;
         off_q     <= '0;
         acc_q     <= '0;
         entry_q   <= '0;
         rsp_paddr <= '0;
         rsp_fault <= FLT_NONE;
      end else begin
         unique case (state)
            ST_IDLE: if (take) begin
               mem_addr <= entry_addr;
               off_q    <= offset;
               acc_q    <= acc;
               state    <= ST_FETCH;
            end
            ST_FETCH: if (mem_ack) begin
               entry_q <= mem_rdata;
               state   <= ST_EVAL;
            end
            ST_EVAL: begin
               rsp_fault <= chk_fault;
               mem_wdata <= chk_upd;
               if (chk_fault == FLT_NONE)
                  rsp_paddr <= {entry_q[PAGE_BITS +: FRAME_W], off_q};
               else
                  rsp_paddr <= '0;
               state <= chk_store ? ST_STORE : ST_REPLY;
            end
            ST_STORE: if (mem_ack) state <= ST_REPLY;
            ST_REPLY: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign idle      = (state == ST_IDLE);
   assign rsp_valid = (state == ST_REPLY);
   assign mem_req   = (state == ST_FETCH) || (state == ST_STORE);
   assign mem_we    = (state == ST_STORE);
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
   import pgw_pkg::*;
#(
   parameter int unsigned VA_W         = 32,
   parameter int unsigned PA_W         = 32,
   parameter int unsigned PTE_W        = 32,
   parameter int unsigned PAGE_BITS    = 12,
   parameter bit          BASE_ALIGNED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             base_load,
   input  logic [PA_W-1:0]  base_value,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [1:0]       req_acc,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic [1:0]       rsp_fault,
   output logic             mem_req,
   output logic             mem_we,
   output logic [PA_W-1:0]  mem_addr,
   output logic [PTE_W-1:0] mem_wdata,
   input  logic             mem_ack,
   input  logic [PTE_W-1:0] mem_rdata
);
   localparam int unsigned VPN_W       = VA_W - PAGE_BITS;
   localparam int unsigned FRAME_W     = PA_W - PAGE_BITS;
   localparam int unsigned ENTRY_BYTES = PTE_W / 8;
   localparam int unsigned ENTRY_SHIFT = $clog2(ENTRY_BYTES);

   if (PTE_W != 32 && PTE_W != 64) begin : g_bad_entry
      $error("pgw_walker: entry width must be 32 or 64");
   end
   if (PAGE_BITS + FRAME_W > PTE_W) begin : g_bad_frame
      $error("pgw_walker: frame field does not fit in entry");
   end
   if (PAGE_BITS < FLAG_BITS || VA_W <= PAGE_BITS) begin : g_bad_page
      $error("pgw_walker: page size inconsistent with address width");
   end

   logic [PA_W-1:0]  base_q;
   logic [PA_W-1:0]  entry_addr;
   logic             idle;
   logic             take;
   logic [PTE_W-1:0] entry_q;
   logic [1:0]       acc_q;
   logic [1:0]       chk_fault;
   logic [PTE_W-1:0] chk_upd;
   logic             chk_store;

   always_ff @(posedge clk) begin
      if (!rst_n)
         base_q <= '0;
      else if (base_load)
         base_q <= base_value;
   end

   assign req_ready = idle;
   assign take      = req_valid && idle;

   pgw_entry_addr #(
      .VPN_W(VPN_W), .PA_W(PA_W), .ENTRY_SHIFT(ENTRY_SHIFT),
      .BASE_ALIGNED(BASE_ALIGNED)
   ) u_addr (
      .base(base_q),
      .vpn(req_vaddr[VA_W-1:PAGE_BITS]),
      .entry_addr(entry_addr)
   );

   pgw_entry_check #(.PTE_W(PTE_W)) u_check (
      .entry(entry_q),
      .acc(acc_q),
      .fault(chk_fault),
      .entry_upd(chk_upd),
      .needs_store(chk_store)
   );

   pgw_ctrl #(.PA_W(PA_W), .PTE_W(PTE_W), .PAGE_BITS(PAGE_BITS)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .take(take),
      .entry_addr(entry_addr),
      .offset(req_vaddr[PAGE_BITS-1:0]),
      .acc(req_acc),
      .idle(idle),
      .entry_q(entry_q),
      .acc_q(acc_q),
      .chk_fault(chk_fault),
      .chk_upd(chk_upd),
      .chk_store(chk_store),
      .rsp_valid(rsp_valid),
      .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault),
      .mem_req(mem_req),
      .mem_we(mem_we),
      .mem_addr(mem_addr),
      .mem_wdata(mem_wdata),
      .mem_ack(mem_ack),
      .mem_rdata(mem_rdata)
   );
endmodule

// File: rtl/pgw_walker_chk.sv
module pgw_walker_chk #(
   parameter int unsigned PA_W  = 32,
   parameter int unsigned PTE_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic [PA_W-1:0]  rsp_paddr,
   input logic [1:0]       rsp_fault,
   input logic             mem_req,
   input logic             mem_we,
   input logic [PA_W-1:0]  mem_addr,
   input logic [PTE_W-1:0] mem_wdata,
   input logic             mem_ack
);
   // R1: never ready while a memory access or a reply is outstanding
   p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req || rsp_valid) |-> !req_ready);

   // R2: a pending entry access keeps its address until acknowledged
   p_addr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R4: a faulting reply carries no translation
   p_fault_no_pa_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));

   // R5: only the three defined fault codes appear
   p_fault_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault != 2'b11));

   // R6: every write-back marks the page referenced
   p_store_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[1]);

   // R7: a write-back is always followed by the reply, never a second access
   p_store_then_reply_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (rsp_valid && !mem_req));

   // R8: the reply lasts exactly one cycle
   p_reply_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R8: after the reply the walker is idle again
   p_reply_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> req_ready);
endmodule

bind pgw_walker pgw_walker_chk #(.PA_W(PA_W), .PTE_W(PTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/tb_pgw_walker.sv
`timescale 1ns/1ps
module tb_pgw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_load = 1'b0;
   logic [31:0] base_value = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_fault;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   always #5 clk = ~clk;

   pgw_walker dut (
      .clk(clk), .rst_n(rst_n), .base_load(base_load), .base_value(base_value),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata)
   );

   // memory model: 256 words indexed by address bits 9:2, one-cycle acknowledge
   logic [31:0] mem [256];
   logic        poke_en = 1'b0;
   logic [7:0]  poke_idx = '0;
   logic [31:0] poke_val = '0;
   logic [31:0] last_rd_addr = '0;
   logic [31:0] last_wr_addr = '0;
   int          wr_count = 0;
   int          rsp_count = 0;
   int          cycles = 0;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (rsp_valid) rsp_count <= rsp_count + 1;
      if (poke_en) mem[poke_idx] <= poke_val;
      if (mem_req && !mem_ack) begin
         mem_ack   <= 1'b1;
         mem_rdata <= mem[mem_addr[9:2]];
         if (mem_we) begin
            mem[mem_addr[9:2]] <= mem_wdata;
            wr_count     <= wr_count + 1;
            last_wr_addr <= mem_addr;
         end else begin
            last_rd_addr <= mem_addr;
         end
      end else begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
      end
   end

   int n_checks = 0;
   int n_fail   = 0;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic poke(input logic [7:0] idx, input logic [31:0] val);
      @(negedge clk);
      poke_en = 1'b1; poke_idx = idx; poke_val = val;
      @(negedge clk);
      poke_en = 1'b0;
   endtask

   task automatic load_base(input logic [31:0] val);
      @(negedge clk);
      base_load = 1'b1; base_value = val;
      @(negedge clk);
      base_load = 1'b0;
   endtask

   logic [31:0] got_paddr;
   logic [1:0]  got_fault;
   logic        busy_ready;
   logic        mid_load = 1'b0;
   logic [31:0] mid_value = '0;

   task automatic walk(input logic [31:0] va, input logic [1:0] acc);
      int wait_n;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_acc = acc;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      busy_ready = req_ready;
      if (mid_load) begin
         base_load = 1'b1; base_value = mid_value;
         @(negedge clk);
         base_load = 1'b0;
      end
      wait_n = 0;
      while (!rsp_valid && wait_n < 100) begin
         @(negedge clk);
         wait_n++;
      end
      got_paddr = rsp_paddr;
      got_fault = rsp_fault;
      if (!rsp_valid) chk("R8", "response never arrived", 32'd0, 32'd1);
   endtask

   // vector table: address, access, entry, fault, write-back expected, entry afterwards
   localparam int NV = 12;
   localparam logic [31:0] V_VA [NV] = '{
      32'h0000_5328, 32'h0000_6ABC, 32'h0000_7004, 32'h0000_8010,
      32'h0000_9FFF, 32'h0000_A123, 32'h0000_B000, 32'h0000_C444,
      32'h0000_D0D0, 32'h0000_E777, 32'h0000_F001, 32'h0001_0200};
   localparam logic [1:0] V_ACC [NV] = '{
      2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd0, 2'd1, 2'd2, 2'd0, 2'd3, 2'd1, 2'd1};
   localparam logic [31:0] V_PTE [NV] = '{
      32'h0300_4009, 32'h0ABC_D019, 32'h0004_2021, 32'h0001_100B,
      32'h0002_201F, 32'h0300_4038, 32'h0003_3009, 32'h0004_4019,
      32'h0005_5011, 32'h0006_6009, 32'h0007_7000, 32'h0008_801B};
   localparam logic [1:0] V_FLT [NV] = '{
      2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd2, 2'd2, 2'd0, 2'd1, 2'd0};
   localparam logic V_WB [NV] = '{
      1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
   localparam logic [31:0] V_FIN [NV] = '{
      32'h0300_400B, 32'h0ABC_D01F, 32'h0004_2023, 32'h0001_100B,
      32'h0002_201F, 32'h0300_4038, 32'h0003_3009, 32'h0004_4019,
      32'h0005_5011, 32'h0006_600B, 32'h0007_7000, 32'h0008_801F};

   function automatic string tag_of(input int i);
      case (i)
         3, 4:        return "R7";
         5, 10:       return "R4";
         6, 7, 8, 9:  return "R5";
         default:     return "R6";
      endcase
   endfunction

   initial begin : watchdog
      wait (cycles > 50000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fail);
      $finish;
   end

   initial begin : main
      int wr0, rsp0, req_n;
      logic [31:0] exp_pa, idx_addr;
      mem_ack = 1'b0;
      mem_rdata = '0;
      for (int k = 0; k < 256; k++) mem[k] = '0;
      repeat (3) @(negedge clk);
      // R10: state right after reset is released
      rst_n = 1'b1;
      chk("R10", "ready after reset", {31'd0, req_ready}, 32'd1);
      chk("R10", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
      chk("R10", "mem_req after reset", {31'd0, mem_req}, 32'd0);
      req_n = 0;

      // R3 / R10: base is zero after reset; worked example
      poke(8'h25, 32'h0300_4009);
      walk(32'h1332_5328, 2'd0); req_n++;
      chk("R10", "base zero gives entry address", last_rd_addr, 32'h0004_CC94);
      chk("R3", "example physical address", got_paddr, 32'h0300_4328);
      chk("R3", "example fault code", {30'd0, got_fault}, 32'd0);
      chk("R1", "ready low during walk", {31'd0, busy_ready}, 32'd0);

      // R9: base register load takes effect for the next request
      load_base(32'h0000_1000);

      for (int i = 0; i < NV; i++) begin
         idx_addr = 32'h0000_1000 + {V_VA[i][31:12], 2'b00};
         poke(idx_addr[9:2], V_PTE[i]);
         wr0 = wr_count;
         walk(V_VA[i], V_ACC[i]); req_n++;
         exp_pa = (V_FLT[i] == 2'd0) ? {V_PTE[i][31:12], V_VA[i][11:0]} : 32'd0;
         chk("R2", "entry read address", last_rd_addr, idx_addr);
         chk(tag_of(i), "fault code", {30'd0, got_fault}, {30'd0, V_FLT[i]});
         chk("R3", "physical address", got_paddr, exp_pa);
         chk(tag_of(i), "write-back count", wr_count - wr0, V_WB[i] ? 1 : 0);
         chk(tag_of(i), "entry after walk", mem[idx_addr[9:2]], V_FIN[i]);
         if (V_WB[i]) chk("R6", "write-back address", last_wr_addr, idx_addr);
      end

      // R8: response pulse is gone on the next cycle
      @(negedge clk);
      chk("R8", "rsp_valid drops after one cycle", {31'd0, rsp_valid}, 32'd0);

      // R9: base change during a walk does not redirect it
      poke(8'h30, 32'h0012_3009);
      mid_load = 1'b1; mid_value = 32'h0000_2000;
      walk(32'h0003_0ABC, 2'd0); req_n++;
      mid_load = 1'b0;
      chk("R9", "walk in flight keeps old base", last_rd_addr, 32'h0000_10C0);
      chk("R9", "translation of in-flight walk", got_paddr, 32'h0012_3ABC);
      poke(8'h31, 32'h0045_6009);
      walk(32'h0003_1000, 2'd0); req_n++;
      chk("R9", "next walk uses new base", last_rd_addr, 32'h0000_20C4);
      chk("R9", "translation with new base", got_paddr, 32'h0045_6000);

      // R1: a request held high during a walk is only taken once
      poke(8'h32, 32'h0011_100B);
      wr0 = wr_count; rsp0 = rsp_count;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = 32'h0003_2000; req_acc = 2'd0;
      @(posedge clk);
      #1;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
      repeat (10) @(negedge clk);
      req_n++;
      chk("R1", "held request answered once", rsp_count - rsp0, 32'd1);
      chk("R7", "no store for already-referenced read", wr_count - wr0, 32'd0);

      // R8: one response per accepted request overall
      chk("R8", "total responses", rsp_count, req_n);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule